// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block supervises software by counting system clocks against a selectable time-out period. Software keeps the system alive by writing a two-byte key to a service register: first 0x55, then 0xAA. The completed pair restarts the period. If the period runs out, or software writes a wrong byte, the block raises a one-cycle reset request for the chip's reset logic to stretch and apply.

A 3-bit rate select chooses among seven power-of-two periods, and code 000 turns the watchdog off. An optional window mode catches runaway code that services too often. In that mode any service write before the last quarter of the period is a fault. The time base is set by a parameter, so a small value gives short periods for simulation.

Top module: `wdt_key_window`

## Requirements
- R1: With rate code n (1..7) and no service, the count starts at zero and `rst_req_o` goes high in the cycle after the 2^(BASE_EXP+2n)-th rising clock edge. That edge is the one where the count already stood at the period minus one.
- R2: Rate code 000 disables the block. The count is held at zero, writes are ignored and no request is raised. After enabling, a full period elapses before expiry.
- R3: A write of 0x55 followed later by a write of 0xAA restarts the period from zero and raises no request.
- R4: Writing 0x55 again while already armed keeps the sequence armed, so a later 0xAA still restarts the period without a request.
- R5: A write of 0xAA that is not preceded by an arming 0x55 raises a request.
- R6: A write of any value other than 0x55 or 0xAA raises a request.
- R7: With `win_en_i` high, a service write while the count is below three quarters of the period raises a request. Writes at or above that point are accepted.
- R8: An 0xAA that completes the sequence in the final cycle of the period, when the count equals the period minus one, restarts the period and suppresses expiry.
- R9: `rst_req_o` is a single-cycle pulse. On that cycle the count is zero and the key sequence is unarmed, so a new full period begins.
- R10: A request caused by a write appears in the cycle right after the write cycle.
- R11: Asserting `rst_ni` (active low, asynchronous) clears the count, the key state and `rst_req_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the service register |
| wr_data_i | input | 8 | Service register write data |
| rate_sel_i | input | 3 | Period select, 000 disables |
| win_en_i | input | 1 | Window mode enable |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Sequence completion and period expiry can fall in the same cycle. The bench provokes this by writing 0x55 at the opening of the window of an 8-clock period and then 0xAA in the very next cycle, while the count sits at its last value. The judgement is that the request output stays low after that edge, because the restart takes precedence. A later expiry check then confirms that a fresh full period was started.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned NUM_RATES = 1 << RATE_W;
  localparam logic [7:0] KEY_FIRST = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  typedef struct packed {
    logic first;
    logic second;
    logic other;
  } key_dec_t;

  function automatic key_dec_t decode_key(input logic [7:0] data);
    key_dec_t d;
    d.first  = (data == KEY_FIRST);
    d.second = (data == KEY_SECOND);
    d.other  = !(d.first || d.second);
    return d;
  endfunction
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 9,
  parameter int unsigned CNT_W    = BASE_EXP + 2 * (NUM_RATES - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              clear_i,
  output logic              enabled_o,
  output logic              expire_o,
  output logic              win_open_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] period_m1 [NUM_RATES];
  logic [CNT_W-1:0] win_start [NUM_RATES];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // per-code period and window thresholds, built at elaboration
  assign period_m1[0] = '0;
  assign win_start[0] = '0;
  for (genvar g = 1; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned SH = BASE_EXP + 2 * g;
    localparam logic [CNT_W:0] PER = (CNT_W + 1)'(1) << SH;
    localparam logic [CNT_W:0] PM1 = PER - (CNT_W + 1)'(1);
    localparam logic [CNT_W:0] WST = PER - (PER >> 2);
    assign period_m1[g] = PM1[CNT_W-1:0];
    assign win_start[g] = WST[CNT_W-1:0];
  end

  assign enabled_o  = (rate_sel_i != '0);
  assign expire_o   = enabled_o && (cnt_q >= period_m1[rate_sel_i]);
  assign win_open_o = (cnt_q >= win_start[rate_sel_i]);
  assign cnt_o      = cnt_q;

  always_comb begin
    if (!enabled_o || clear_i) cnt_d = '0;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_disabled_holds_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |=> (cnt_q == '0));

  p_clear_zeroes_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       enabled_i,
  input  logic       clear_i,
  output logic       service_o,
  output logic       restart_o,
  output logic       bad_key_o,
  output logic       armed_o
);
  key_state_e state_q, state_d;
  key_dec_t   dec;
  logic       wr_act;

  assign dec       = decode_key(wr_data_i);
  assign wr_act    = wr_en_i && enabled_i;
  assign armed_o   = (state_q == KEY_ARMED);
  assign service_o = wr_act;
  assign restart_o = wr_act && dec.second && armed_o;
  // stray 0xAA or any foreign byte
  assign bad_key_o = wr_act && (dec.other || (dec.second && !armed_o));

  always_comb begin
    state_d = state_q;
    if (clear_i || !enabled_i)  state_d = KEY_IDLE;
    else if (wr_act && dec.first) state_d = KEY_ARMED;
    else if (restart_o)           state_d = KEY_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  p_first_key_arms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && dec.first && !clear_i) |=> armed_o);

  p_restart_disarms_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !armed_o);
endmodule

// File: rtl/wdt_key_window.sv
module wdt_key_window
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              win_en_i,
  output logic              rst_req_o
);
  localparam int unsigned CNT_W = BASE_EXP + 2 * (NUM_RATES - 1);

  logic             enabled, expire, win_open;
  logic [CNT_W-1:0] cnt;
  logic             service, restart, bad_key, armed;
  logic             early, fault, cnt_clear;
  logic             rst_req_q;

  // restart beats expiry in the last cycle of the period
  assign early     = win_en_i && service && !win_open;
  assign fault     = enabled && (bad_key || early || (expire && !restart));
  assign cnt_clear = fault || restart;

  wdt_timebase #(
    .BASE_EXP(BASE_EXP),
    .CNT_W   (CNT_W)
  ) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_sel_i(rate_sel_i),
    .clear_i   (cnt_clear),
    .enabled_o (enabled),
    .expire_o  (expire),
    .win_open_o(win_open),
    .cnt_o     (cnt)
  );

  wdt_key_seq u_key_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .enabled_i(enabled),
    .clear_i  (fault),
    .service_o(service),
    .restart_o(restart),
    .bad_key_o(bad_key),
    .armed_o  (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= fault;
  end

  assign rst_req_o = rst_req_q;

  p_idle_on_request_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ((cnt == '0) && !armed));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !(wr_en_i && enabled)) |=> !rst_req_o);

  p_disabled_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |=> !rst_req_o);

  p_foreign_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled && wr_en_i && wr_data_i != KEY_FIRST && wr_data_i != KEY_SECOND)
      |=> rst_req_o);

  p_expiry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !restart) |=> rst_req_o);

  p_restart_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !early) |=> !rst_req_o);
endmodule

// File: tb/wdt_key_window_tb_top.sv
`timescale 1ns/1ps
module wdt_key_window_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [2:0] rate_sel_i = 3'd0;
  logic       win_en_i = 1'b0;
  logic       rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  wdt_key_window #(.BASE_EXP(1)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rate_sel_i(rate_sel_i),
    .win_en_i  (win_en_i),
    .rst_req_o (rst_req_o)
  );

  // rate,win,gap1,d1,exp1,gap2,d2,exp2,req ; BASE_EXP=1: code1 -> 8 clocks, code2 -> 32, code3 -> 128
  typedef struct packed {
    logic [2:0] rate;
    logic       win;
    logic [7:0] gap1;
    logic [7:0] d1;
    logic       exp1;
    logic [7:0] gap2;
    logic [7:0] d2;
    logic       exp2;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 8'd2,   8'h55, 1'b0, 8'd1,  8'hAA, 1'b0, 4'd3},  // R3
    '{3'd1, 1'b0, 8'd1,   8'hAA, 1'b1, 8'd0,  8'h55, 1'b0, 4'd5},  // R5
    '{3'd1, 1'b0, 8'd0,   8'h12, 1'b1, 8'd3,  8'hAA, 1'b1, 4'd6},  // R6 then R5
    '{3'd1, 1'b1, 8'd2,   8'h55, 1'b1, 8'd0,  8'h55, 1'b1, 4'd7},  // R7 early
    '{3'd1, 1'b1, 8'd6,   8'h55, 1'b0, 8'd0,  8'hAA, 1'b0, 4'd8},  // R8 final cycle
    '{3'd0, 1'b1, 8'd1,   8'h12, 1'b0, 8'd2,  8'hAA, 1'b0, 4'd2},  // R2 ignored
    '{3'd1, 1'b0, 8'd1,   8'h55, 1'b0, 8'd0,  8'h55, 1'b0, 4'd4},  // R4
    '{3'd2, 1'b1, 8'd23,  8'h55, 1'b1, 8'd0,  8'h55, 1'b1, 4'd7},  // R7 one short
    '{3'd2, 1'b1, 8'd24,  8'h55, 1'b0, 8'd2,  8'hAA, 1'b0, 4'd7},  // R7 open
    '{3'd3, 1'b0, 8'd100, 8'h55, 1'b0, 8'd20, 8'hAA, 1'b0, 4'd10}  // R10
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_req_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] rate, input logic win);
    @(negedge clk_i);
    rst_ni = 1'b0;
    wr_en_i = 1'b0;
    rate_sel_i = rate;
    win_en_i = win;
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(req, rst_req_o, 1'b0);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic exp, input string req);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(req, rst_req_o, exp);
  endtask

  initial begin
    // R11 reset state
    rst_ni = 1'b0;
    #1;
    chk("R11", rst_req_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      do_reset(VECS[v].rate, VECS[v].win);
      idle(int'(VECS[v].gap1), tag);
      wr(VECS[v].d1, VECS[v].exp1, tag);
      idle(int'(VECS[v].gap2), tag);
      wr(VECS[v].d2, VECS[v].exp2, tag);
    end

    // R1 expiry at 8 clocks, R9 single pulse and fresh period
    do_reset(3'd1, 1'b0);
    idle(7, "R1");
    @(posedge clk_i); @(negedge clk_i);
    chk("R1", rst_req_o, 1'b1);
    @(posedge clk_i); @(negedge clk_i);
    chk("R9", rst_req_o, 1'b0);
    idle(6, "R9");
    @(posedge clk_i); @(negedge clk_i);
    chk("R9", rst_req_o, 1'b1);

    // R3 restart pushes expiry a full period out
    do_reset(3'd1, 1'b0);
    idle(3, "R3");
    wr(8'h55, 1'b0, "R3");
    wr(8'hAA, 1'b0, "R3");
    idle(7, "R3");
    @(posedge clk_i); @(negedge clk_i);
    chk("R3", rst_req_o, 1'b1);

    // R4 double arm then complete
    do_reset(3'd1, 1'b0);
    wr(8'h55, 1'b0, "R4");
    wr(8'h55, 1'b0, "R4");
    wr(8'hAA, 1'b0, "R4");
    idle(7, "R4");
    @(posedge clk_i); @(negedge clk_i);
    chk("R4", rst_req_o, 1'b1);

    // R8 restart in final cycle starts a fresh period
    do_reset(3'd1, 1'b1);
    idle(6, "R8");
    wr(8'h55, 1'b0, "R8");
    wr(8'hAA, 1'b0, "R8");
    idle(7, "R8");
    @(posedge clk_i); @(negedge clk_i);
    chk("R8", rst_req_o, 1'b1);

    // R2 long disable, then full period after enabling
    do_reset(3'd0, 1'b0);
    idle(300, "R2");
    rate_sel_i = 3'd1;
    idle(7, "R2");
    @(posedge clk_i); @(negedge clk_i);
    chk("R2", rst_req_o, 1'b1);

    // R11 async reset mid-count
    do_reset(3'd1, 1'b0);
    idle(5, "R11");
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R11", rst_req_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(7, "R11");
    @(posedge clk_i); @(negedge clk_i);
    chk("R11", rst_req_o, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected <= %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule